// File: doc/BRIEF.md
# Baud Divider Parameter Solver

This unit works out the settings for a UART baud generator. It takes a base clock rate in Hz, a requested baud rate and a clock source index. It returns a packed configuration word and an oversampling word. A downstream generator decodes both words.

The solver first tries 16x oversampling with both prescalers at 1. If the rounded main divider does not fit in 10 bits, it moves to coarser settings in a fixed order:

1. Raise the first prescaler to 6.
2. Raise the second prescaler to 6.
3. Switch to 63x oversampling.

Each step reruns a long restoring division.

A one-cycle `start_i` pulse launches a solve. `done_o` pulses once when the results are loaded. The results hold until the next solve completes.

Top module: `baud_solver`

## Requirements
- R1: The divider is round-half-up of rate / (baud × F × p1 × p2), computed as (rate + den/2) / den. The first attempt uses F = 16 and p1 = p2 = 1. The packed word sets bit 19, puts p1 in bits [17:15], p2 in bits [14:12], the source index in bits [11:10] and the divider in bits [9:0], and leaves all other bits zero.
- R2: If the first result is above 1023, the solver sets p1 = 6 and recomputes. A result of exactly 1023 is kept.
- R3: If the p1 = 6 result is still above 1023, the solver also sets p2 = 6 and recomputes.
- R4: If that result is still above 1023, the solver uses F = 63. In that case `ovs_o` is 0x3F3F3F3F, with 63 in each of its four byte fields.
- R5: A divider that rounds to 0 is raised to 1.
- R6: In the 63x stage, a divider above 1023 is clamped to 1023.
- R7: When 16x oversampling is used, `ovs_o` is zero.
- R8: A baud request of zero finishes with `err_o` = 1. The divider is 1023, p1 = p2 = 1, the index is as given and `ovs_o` is 0. The next valid solve clears `err_o`.
- R9: `done_o` is high for exactly one cycle per solve. `busy_o` is high from the cycle after an accepted start until `done_o` rises, and is low while `done_o` is high.
- R10: A start pulse while `busy_o` is high is ignored. The solve in progress finishes with its own inputs, and no extra solve follows.
- R11: After reset all outputs are zero. `cfg_o`, `ovs_o` and `err_o` change only in the cycle in which `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a solve (sampled only when idle) |
| rate_i | input | 32 | Base clock rate in Hz |
| baud_i | input | 32 | Requested baud rate |
| src_idx_i | input | 2 | Clock source index placed in the packed word |
| busy_o | output | 1 | Solve in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cfg_o | output | 32 | Packed divider configuration word |
| ovs_o | output | 32 | Oversampling word |
| err_o | output | 1 | Baud request was zero |

## Verification
The bench sets up requests that land exactly on each escalation threshold:

- **1023 stays, 1024 escalates.** A design that compares with >= instead of > would move to the next stage one value too early.
- **Half rounds up, just below half truncates.** This catches truncating division or rounding on the wrong side.
- **Deep escalation.** Slow baud rates on a fast clock exercise each deeper stage, which shows a design that skips a stage or packs a field in the wrong place.
- **Clamping at both ends.** Extreme ratios must give 1 and 1023 rather than zero or a wrapped value.
- **Zero baud.** Must end with the error flag set, not hang in the division.
- **Start while busy.** A design that restarts on this pulse would report the second request, or finish twice.

// File: rtl/baud_solver_pkg.sv
package baud_solver_pkg;
  localparam int unsigned CFG_W       = 32;
  localparam int unsigned SRC_SEL_BIT = 19;
  localparam int unsigned P1_LSB      = 15;
  localparam int unsigned P2_LSB      = 12;
  localparam int unsigned IDX_LSB     = 10;
  localparam int unsigned P_W         = 3;
  localparam int unsigned MUL_W       = 12;  // holds 63*6*6
  localparam int unsigned LAST_STAGE  = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_WAIT,
    ST_ZERO
  } solver_state_e;
endpackage

// File: rtl/baud_solver_div.sv
module baud_solver_div #(
  parameter int unsigned NUM_W = 45,
  parameter int unsigned DEN_W = 44
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int unsigned CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q, den_q, rem_nx;
  logic [NUM_W-1:0] quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [DEN_W:0]   trial, diff;
  logic             ge;

  always_comb begin
    trial  = {rem_q, quo_q[NUM_W-1]};
    diff   = trial - {1'b0, den_q};
    ge     = trial >= {1'b0, den_q};
    rem_nx = ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        rem_q <= '0;
        quo_q <= num_i;
        den_q <= den_i;
        cnt_q <= CNT_W'(NUM_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= rem_nx;
        quo_q <= {quo_q[NUM_W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quo_o = quo_q;
endmodule

// File: rtl/baud_solver_stage.sv
module baud_solver_stage
  import baud_solver_pkg::*;
#(
  parameter int unsigned OVS_FW   = 8,
  parameter int unsigned OVS_N    = 4,
  parameter int unsigned OVS_BASE = 16,
  parameter int unsigned OVS_MAX  = 63,
  parameter int unsigned P_MAX    = 6
) (
  input  logic [1:0]              stage_i,
  output logic [P_W-1:0]          p1_o,
  output logic [P_W-1:0]          p2_o,
  output logic [MUL_W-1:0]        mul_o,
  output logic [OVS_FW*OVS_N-1:0] ovs_o
);
  logic [MUL_W-1:0] f;

  always_comb begin
    p1_o = (stage_i >= 2'd1) ? P_W'(P_MAX) : P_W'(1);
    p2_o = (stage_i >= 2'd2) ? P_W'(P_MAX) : P_W'(1);
    f    = (stage_i == 2'(LAST_STAGE)) ? MUL_W'(OVS_MAX) : MUL_W'(OVS_BASE);
    mul_o = f * MUL_W'(p1_o) * MUL_W'(p2_o);
  end

  for (genvar g = 0; g < OVS_N; g++) begin : g_ovs
    assign ovs_o[g*OVS_FW +: OVS_FW] =
      (stage_i == 2'(LAST_STAGE)) ? OVS_FW'(OVS_MAX) : '0;
  end
endmodule

// File: rtl/baud_solver_pack.sv
module baud_solver_pack
  import baud_solver_pkg::*;
#(
  parameter int unsigned DIV_W = 10,
  parameter int unsigned IDX_W = 2
) (
  input  logic [DIV_W-1:0] div_i,
  input  logic [P_W-1:0]   p1_i,
  input  logic [P_W-1:0]   p2_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [CFG_W-1:0] cfg_o
);
  always_comb begin
    cfg_o = '0;
    cfg_o[DIV_W-1:0]                = div_i;
    cfg_o[IDX_LSB +: IDX_W]         = idx_i;
    cfg_o[P2_LSB +: P_W]            = p2_i;
    cfg_o[P1_LSB +: P_W]            = p1_i;
    cfg_o[SRC_SEL_BIT]              = 1'b1;
  end
endmodule

// File: rtl/baud_solver.sv
module baud_solver
  import baud_solver_pkg::*;
#(
  parameter int unsigned RATE_W = 32,
  parameter int unsigned BAUD_W = 32,
  parameter int unsigned DIV_W  = 10,
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned OVS_FW = 8,
  parameter int unsigned OVS_N  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [RATE_W-1:0]       rate_i,
  input  logic [BAUD_W-1:0]       baud_i,
  input  logic [IDX_W-1:0]        src_idx_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [CFG_W-1:0]        cfg_o,
  output logic [OVS_FW*OVS_N-1:0] ovs_o,
  output logic                    err_o
);
  localparam int unsigned DEN_W   = BAUD_W + MUL_W;
  localparam int unsigned NUM_W   = ((RATE_W > DEN_W) ? RATE_W : DEN_W) + 1;
  localparam int unsigned DIV_MAX = (1 << DIV_W) - 1;
  localparam int unsigned OVS_W   = OVS_FW * OVS_N;

  solver_state_e      st_q;
  logic [1:0]         stage_q;
  logic [RATE_W-1:0]  rate_q;
  logic [BAUD_W-1:0]  baud_q;
  logic [IDX_W-1:0]   idx_q;

  logic [P_W-1:0]     p1, p2;
  logic [MUL_W-1:0]   mul;
  logic [OVS_W-1:0]   ovs_nx;
  logic [DEN_W-1:0]   den;
  logic [NUM_W-1:0]   num, quo;
  logic               div_start, div_done, too_big;
  logic [DIV_W-1:0]   div_fin, div_sel;
  logic [CFG_W-1:0]   cfg_nx;

  baud_solver_stage #(.OVS_FW(OVS_FW), .OVS_N(OVS_N)) i_stage (
    .stage_i (stage_q),
    .p1_o    (p1),
    .p2_o    (p2),
    .mul_o   (mul),
    .ovs_o   (ovs_nx)
  );

  always_comb begin
    den       = DEN_W'(baud_q) * DEN_W'(mul);
    num       = NUM_W'(rate_q) + NUM_W'(den >> 1);
    div_start = (st_q == ST_LAUNCH);
  end

  baud_solver_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) i_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_start),
    .num_i   (num),
    .den_i   (den),
    .done_o  (div_done),
    .quo_o   (quo)
  );

  always_comb begin
    too_big = quo > NUM_W'(DIV_MAX);
    if (quo == '0)   div_fin = DIV_W'(1);
    else if (too_big) div_fin = DIV_W'(DIV_MAX);
    else              div_fin = quo[DIV_W-1:0];
    div_sel = (st_q == ST_ZERO) ? DIV_W'(DIV_MAX) : div_fin;
  end

  baud_solver_pack #(.DIV_W(DIV_W), .IDX_W(IDX_W)) i_pack (
    .div_i (div_sel),
    .p1_i  (p1),
    .p2_i  (p2),
    .idx_i (idx_q),
    .cfg_o (cfg_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      stage_q <= '0;
      rate_q  <= '0;
      baud_q  <= '0;
      idx_q   <= '0;
      cfg_o   <= '0;
      ovs_o   <= '0;
      err_o   <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          rate_q  <= rate_i;
          baud_q  <= baud_i;
          idx_q   <= src_idx_i;
          stage_q <= '0;
          st_q    <= (baud_i == '0) ? ST_ZERO : ST_LAUNCH;
        end
        ST_LAUNCH: st_q <= ST_WAIT;
        ST_WAIT: if (div_done) begin
          if (too_big && stage_q != 2'(LAST_STAGE)) begin
            stage_q <= stage_q + 2'd1;
            st_q    <= ST_LAUNCH;
          end else begin
            cfg_o  <= cfg_nx;
            ovs_o  <= ovs_nx;
            err_o  <= 1'b0;
            done_o <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        ST_ZERO: begin
          cfg_o  <= cfg_nx;
          ovs_o  <= '0;
          err_o  <= 1'b1;
          done_o <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);
endmodule

// File: rtl/baud_solver_chk.sv
module baud_solver_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic [31:0] cfg_o,
  input logic [31:0] ovs_o,
  input logic        err_o
);
  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_idle_on_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_start_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !done_o && start_i) |=> busy_o || done_o);

  assert_busy_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));

  assert_hold_outputs_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($stable(cfg_o) && $stable(ovs_o) && $stable(err_o)) |-> done_o);

  assert_src_bit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cfg_o[19] && !cfg_o[18] && cfg_o[31:20] == '0);

  assert_ovs_coarse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ovs_o != '0) |-> (ovs_o == 32'h3F3F3F3F && cfg_o[17:15] == 3'd6
                                 && cfg_o[14:12] == 3'd6));

  assert_div_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cfg_o[9:0] != '0);

  assert_zero_baud_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (cfg_o[9:0] == 10'd1023 && ovs_o == '0));
endmodule

bind baud_solver baud_solver_chk i_baud_solver_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .cfg_o   (cfg_o),
  .ovs_o   (ovs_o),
  .err_o   (err_o)
);

// File: tb/test_baud_solver.sv
module test_baud_solver;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  // R1 R2 R3 R4 R5 R6 R7 vectors
  localparam logic [31:0] V_RATE [NV] = '{32'd25000000, 32'd24, 32'd23, 32'd16368,
    32'd16384, 32'd200000000, 32'd200000000, 32'd200000000, 32'd1000000, 32'd4000000000};
  localparam logic [31:0] V_BAUD [NV] = '{32'd115200, 32'd1, 32'd1, 32'd1, 32'd1,
    32'd9600, 32'd1200, 32'd300, 32'd6000000, 32'd1};
  localparam logic [1:0]  V_IDX  [NV] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd3,
    2'd2, 2'd0, 2'd0};
  localparam logic [31:0] V_CFG  [NV] = '{32'h8900E, 32'h89002, 32'h89001, 32'h893FF,
    32'hB10AB, 32'hB14D9, 32'hB6D21, 32'hB6926, 32'h89001, 32'hB63FF};
  localparam logic [31:0] V_OVS  [NV] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
    32'h0, 32'h3F3F3F3F, 32'h0, 32'h3F3F3F3F};
  // requirement each vector targets: R1 R1 R1 R2 R2 R2 R3 R4 R5 R6
  localparam int V_REQ [NV] = '{1, 1, 1, 2, 2, 2, 3, 4, 5, 6};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] rate = '0, baud = '0;
  logic [1:0]  idx = '0;
  logic        busy, done, err;
  logic [31:0] cfg, ovs;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_solver i_baud_solver (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rate_i(rate), .baud_i(baud),
    .src_idx_i(idx), .busy_o(busy), .done_o(done), .cfg_o(cfg), .ovs_o(ovs),
    .err_o(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic kick(input logic [31:0] r, input logic [31:0] b, input logic [1:0] i);
    @(negedge clk);
    rate = r; baud = b; idx = i; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 2000; k++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit seen;
    int extra;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset cfg", cfg, 32'h0);
    chk("R11 reset ovs", ovs, 32'h0);
    chk("R11 reset flags", {29'd0, busy, done, err}, 32'h0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      kick(V_RATE[v], V_BAUD[v], V_IDX[v]);
      chk($sformatf("R9 busy v%0d", v), {31'd0, busy | done}, 32'd1);
      wait_done(seen);
      chk($sformatf("R9 done seen v%0d", v), {31'd0, seen}, 32'd1);
      chk($sformatf("R%0d cfg v%0d", V_REQ[v], v), cfg, V_CFG[v]);
      chk($sformatf("R%0d ovs v%0d (R7 when zero)", V_REQ[v], v), ovs, V_OVS[v]);
      chk($sformatf("R8 err clear v%0d", v), {31'd0, err}, 32'd0);
      @(negedge clk);
      chk($sformatf("R9 done one cycle v%0d", v), {31'd0, done}, 32'd0);
    end

    // R8 zero baud
    kick(32'd50000000, 32'd0, 2'd1);
    wait_done(seen);
    chk("R8 zero baud done", {31'd0, seen}, 32'd1);
    chk("R8 zero baud cfg", cfg, 32'h897FF);
    chk("R8 zero baud ovs", ovs, 32'h0);
    chk("R8 zero baud err", {31'd0, err}, 32'd1);
    kick(32'd25000000, 32'd115200, 2'd0);
    wait_done(seen);
    chk("R8 err cleared by next solve", {31'd0, err}, 32'd0);
    chk("R1 cfg after error", cfg, 32'h8900E);

    // R10 start while busy
    kick(32'd200000000, 32'd300, 2'd2);
    repeat (3) @(negedge clk);
    rate = 32'd25000000; baud = 32'd115200; idx = 2'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(seen);
    chk("R10 busy start ignored cfg", cfg, 32'hB6926);
    chk("R10 busy start ignored ovs", ovs, 32'h3F3F3F3F);

    // R10 R11 no second solve, outputs hold with inputs changing
    extra = 0;
    @(negedge clk);
    rate = 32'd1; baud = 32'd7; idx = 2'd3;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R10 no extra done", extra, 0);
    chk("R11 cfg held", cfg, 32'hB6926);
    chk("R11 ovs held", ovs, 32'h3F3F3F3F);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule